// File: doc/BRIEF.md
# Flash Write-Buffer Command Sequencer

This block runs the multi-write protocol for buffered flash programming. A host opens a sequence with a setup command that names an erase block. It then sends a word count, a start address with the first data word, and the remaining address/data pairs. A confirm command closes the sequence. Each setup loads an extended status byte. Bit 7 of that byte tells the host whether a buffer was granted. When it reads 0, the host sends the setup again until it reads 1.

All commands arrive on one valid/ready write port. A transfer takes place on a rising edge where `cmd_valid` and `cmd_ready` are both high. The sequencer never applies back-pressure. `cmd_ready` is low only while reset is held, so the host only has to keep a command stable until the edge on which it is accepted.

After a valid confirm, the collected words go to a program engine. The engine writes them into a register-modelled flash array, one word every `WORD_CYCLES` clocks. Programming can only clear bits: each stored word becomes old AND new. The engine has its own copy of the data. A second buffer can therefore be loaded and confirmed while the engine is busy, and that buffer then waits until the engine is free. Errors are reported in the status byte. While an error is set, new sequences are refused until the host sends a clear command.

Top module: `wb_sequencer`

## Requirements
- R1: After reset, `sts` reads 8'h80, `xsts` reads 8'h00, and every array word reads all ones.
- R2: Setup is command code 16'h00E8 and carries the block in address bits [AW-1:BW]. It sets `xsts[7]` to 1 and opens a sequence only when no error bit is set and no confirmed buffer is waiting. Otherwise it sets `xsts[7]` to 0 and the sequencer stays idle, so a later retry can succeed.
- R3: The write after a granted setup gives the count as the number of words minus one. A count above DEPTH-1, or a count address outside the set-up block, sets `sts[5]` and `sts[4]` and abandons the buffer.
- R4: If the start address is outside the block, or start plus count passes the end of the erase block, `sts[5]` and `sts[4]` are set and nothing is programmed.
- R5: Each later data write must have an offset from the start address of 0 to count. Any other address sets `sts[5]` and `sts[4]`. A repeated offset overwrites the earlier word. An offset that is never written leaves its array word unchanged.
- R6: The write after the last data word must carry code 16'h00D0. Any other value sets `sts[5]` and `sts[4]`, and nothing is programmed.
- R7: After a valid confirm, each loaded word is programmed as old AND new. `sts[7]` reads 0 while the engine is busy or a buffer is waiting, and it returns to 1 when all programming is done.
- R8: `sts[5]`, `sts[4]` and `sts[1]` hold until an idle write of code 16'h0050 clears all three. While any of them is set, setup is refused.
- R9: If the block's `lock` bit is 1 and `wp_n` is 0 at confirm, `sts[1]` and `sts[4]` are set and nothing is written. With `wp_n` at 1, a locked block is programmed.
- R10: If `vpp_ok` is 0 at confirm, `sts[5]` and `sts[4]` are set and nothing is written.
- R11: A setup while the engine is busy and nothing is waiting is granted. The buffer then confirmed is programmed after the running one.
- R12: `cmd_ready` is 1 whenever reset is released. An idle write of any code other than setup or clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command write valid |
| cmd_ready | output | 1 | Command write ready |
| cmd_addr | input | AW | Write address |
| cmd_data | input | DW | Command code or data word |
| lock | input | NBLK | Per-block lock bits |
| wp_n | input | 1 | Write protect, low enforces locks |
| vpp_ok | input | 1 | Program voltage above lockout |
| sts | output | 8 | Status: 7 ready, 5 sequence/erase error, 4 program error, 1 lock error |
| xsts | output | 8 | Extended status: 7 buffer granted |
| rd_addr | input | AW | Array read address |
| rd_data | output | DW | Array word at `rd_addr` |

## Verification
The assertions assume that `cmd_valid`, `cmd_addr` and `cmd_data` are stable through each accepted edge. They also assume that a clear command is the only thing that may remove an error bit, and that a setup seen while idle is judged against the error and waiting state of that same cycle. The stimulus changes inputs only on falling edges and sends one command per transfer. It waits for `sts[7]` before any setup whose grant depends on the engine having finished. It holds `lock`, `wp_n` and `vpp_ok` steady across each confirm.

// File: rtl/wb_seq_pkg.sv
package wb_seq_pkg;
  localparam logic [7:0] CMD_SETUP   = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;

  typedef enum logic [2:0] {
    ST_IDLE, ST_COUNT, ST_START, ST_DATA, ST_CONF
  } seq_state_e;
endpackage

// File: rtl/wb_seq_ctrl.sv
module wb_seq_ctrl
  import wb_seq_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 7,
  parameter int BW    = 5,
  parameter int NBLK  = 4,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH),
  localparam int NBW  = AW - BW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic [AW-1:0]       cmd_addr,
  input  logic [DW-1:0]       cmd_data,
  input  logic [NBLK-1:0]     lock,
  input  logic                wp_n,
  input  logic                vpp_ok,
  input  logic                eng_busy,
  output logic                err_seq,
  output logic                err_prog,
  output logic                err_lock,
  output logic                grant,
  output logic                pending,
  output logic                idle,
  output logic                start,
  output logic [AW-1:0]       start_base,
  output logic [CW-1:0]       start_cnt,
  output logic [DEPTH*DW-1:0] start_data,
  output logic [DEPTH-1:0]    start_mask
);
  seq_state_e          state_q;
  logic [NBW-1:0]      blk_q;
  logic [AW-1:0]       base_q;
  logic [CW-1:0]       cnt_q, left_q;
  logic [DW-1:0]       buf_q [DEPTH];
  logic [DEPTH-1:0]    mask_q;

  logic          in_blk, conf_code, lock_hit, conf_go, any_err;
  logic [AW-1:0] off;
  logic [BW:0]   end_off;

  assign in_blk    = (cmd_addr[AW-1:BW] == blk_q);
  assign off       = cmd_addr - base_q;
  assign end_off   = {1'b0, cmd_addr[BW-1:0]} + {{(BW+1-CW){1'b0}}, cnt_q};
  assign conf_code = (cmd_data == DW'(CMD_CONFIRM));
  assign lock_hit  = lock[blk_q] && !wp_n;
  assign conf_go   = fire && (state_q == ST_CONF) && conf_code && vpp_ok && !lock_hit;
  assign any_err   = err_seq || err_prog || err_lock;
  assign start     = !eng_busy && (conf_go || pending);
  assign idle      = (state_q == ST_IDLE);

  assign start_base = base_q;
  assign start_cnt  = cnt_q;
  assign start_mask = mask_q;
  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign start_data[g*DW +: DW] = buf_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      blk_q    <= '0;
      base_q   <= '0;
      cnt_q    <= '0;
      left_q   <= '0;
      mask_q   <= '0;
      err_seq  <= 1'b0;
      err_prog <= 1'b0;
      err_lock <= 1'b0;
      grant    <= 1'b0;
      pending  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
    end else begin
      if (pending && !eng_busy) pending <= 1'b0;
      if (fire) begin
        unique case (state_q)
          ST_IDLE: begin
            if (cmd_data == DW'(CMD_SETUP)) begin
              if (any_err || pending) begin
                grant <= 1'b0;
              end else begin
                grant   <= 1'b1;
                blk_q   <= cmd_addr[AW-1:BW];
                mask_q  <= '0;
                state_q <= ST_COUNT;
              end
            end else if (cmd_data == DW'(CMD_CLEAR)) begin
              err_seq  <= 1'b0;
              err_prog <= 1'b0;
              err_lock <= 1'b0;
            end
          end
          ST_COUNT: begin
            if (!in_blk || cmd_data > DW'(DEPTH-1)) begin
              err_seq <= 1'b1; err_prog <= 1'b1; state_q <= ST_IDLE;
            end else begin
              cnt_q   <= cmd_data[CW-1:0];
              state_q <= ST_START;
            end
          end
          ST_START: begin
            if (!in_blk || end_off > (BW+1)'(2**BW - 1)) begin
              err_seq <= 1'b1; err_prog <= 1'b1; state_q <= ST_IDLE;
            end else begin
              base_q    <= cmd_addr;
              buf_q[0]  <= cmd_data;
              mask_q[0] <= 1'b1;
              left_q    <= cnt_q;
              state_q   <= (cnt_q == '0) ? ST_CONF : ST_DATA;
            end
          end
          ST_DATA: begin
            if (off > AW'(cnt_q)) begin
              err_seq <= 1'b1; err_prog <= 1'b1; state_q <= ST_IDLE;
            end else begin
              buf_q[off[CW-1:0]]  <= cmd_data;
              mask_q[off[CW-1:0]] <= 1'b1;
              left_q              <= left_q - 1'b1;
              if (left_q == CW'(1)) state_q <= ST_CONF;
            end
          end
          ST_CONF: begin
            state_q <= ST_IDLE;
            if (!conf_code || !vpp_ok) begin
              err_seq <= 1'b1; err_prog <= 1'b1;
            end else if (lock_hit) begin
              err_lock <= 1'b1; err_prog <= 1'b1;
            end else if (eng_busy) begin
              pending <= 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/wb_prog_engine.sv
module wb_prog_engine #(
  parameter int DW          = 16,
  parameter int AW          = 7,
  parameter int DEPTH       = 16,
  parameter int WORD_CYCLES = 4,
  localparam int CW         = $clog2(DEPTH),
  localparam int WORDS      = 2**AW,
  localparam int WCW        = (WORD_CYCLES > 1) ? $clog2(WORD_CYCLES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [AW-1:0]       start_base,
  input  logic [CW-1:0]       start_cnt,
  input  logic [DEPTH*DW-1:0] start_data,
  input  logic [DEPTH-1:0]    start_mask,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data,
  output logic                busy,
  output logic                wr_en
);
  logic [DW-1:0]       mem [WORDS];
  logic [AW-1:0]       base_q;
  logic [CW-1:0]       cnt_q, idx_q;
  logic [DEPTH*DW-1:0] data_q;
  logic [DEPTH-1:0]    mask_q;
  logic [WCW-1:0]      tick_q;
  logic                word_done;
  logic [AW-1:0]       wr_addr;

  assign word_done = busy && (tick_q == WCW'(WORD_CYCLES-1));
  assign wr_en     = word_done && mask_q[idx_q];
  assign wr_addr   = base_q + AW'(idx_q);
  assign rd_data   = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
      tick_q <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (start) begin
      busy   <= 1'b1;
      base_q <= start_base;
      cnt_q  <= start_cnt;
      data_q <= start_data;
      mask_q <= start_mask;
      idx_q  <= '0;
      tick_q <= '0;
    end else if (busy) begin
      if (word_done) begin
        tick_q <= '0;
        if (wr_en) mem[wr_addr] <= mem[wr_addr] & data_q[idx_q*DW +: DW];
        if (idx_q == cnt_q) busy <= 1'b0;
        else idx_q <= idx_q + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wb_sequencer.sv
module wb_sequencer #(
  parameter int DW          = 16,
  parameter int NBLK        = 4,
  parameter int BLK_WORDS   = 32,
  parameter int DEPTH       = 16,
  parameter int WORD_CYCLES = 4,
  localparam int BW         = $clog2(BLK_WORDS),
  localparam int AW         = $clog2(NBLK * BLK_WORDS),
  localparam int CW         = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [DW-1:0]   cmd_data,
  input  logic [NBLK-1:0] lock,
  input  logic            wp_n,
  input  logic            vpp_ok,
  output logic [7:0]      sts,
  output logic [7:0]      xsts,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data
);
  logic                fire, eng_busy, eng_wr, ctl_pending, ctl_idle, start;
  logic                err_seq, err_prog, err_lock, grant;
  logic [AW-1:0]       start_base;
  logic [CW-1:0]       start_cnt;
  logic [DEPTH*DW-1:0] start_data;
  logic [DEPTH-1:0]    start_mask;

  assign cmd_ready = rst_n;
  assign fire      = cmd_valid && cmd_ready;

  wb_seq_ctrl #(.DW(DW), .AW(AW), .BW(BW), .NBLK(NBLK), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fire(fire), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .lock(lock), .wp_n(wp_n), .vpp_ok(vpp_ok), .eng_busy(eng_busy),
    .err_seq(err_seq), .err_prog(err_prog), .err_lock(err_lock), .grant(grant),
    .pending(ctl_pending), .idle(ctl_idle), .start(start), .start_base(start_base),
    .start_cnt(start_cnt), .start_data(start_data), .start_mask(start_mask)
  );

  wb_prog_engine #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .WORD_CYCLES(WORD_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
    .start_cnt(start_cnt), .start_data(start_data), .start_mask(start_mask),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(eng_busy), .wr_en(eng_wr)
  );

  assign sts  = {!eng_busy && !ctl_pending, 1'b0, err_seq, err_prog, 2'b00, err_lock, 1'b0};
  assign xsts = {grant, 7'b0};
endmodule

// File: rtl/wb_sequencer_chk.sv
module wb_sequencer_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [DW-1:0] cmd_data,
  input logic [7:0]    sts,
  input logic [7:0]    xsts,
  input logic          ctl_idle,
  input logic          ctl_pending,
  input logic          eng_wr
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[4] && !(acc && cmd_data == DW'(8'h50))) |=> sts[4]); // R8
  AST_REFUSE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ctl_idle && cmd_data == DW'(8'hE8) && (sts[4] || sts[5])) |=> !xsts[7]); // R8
  AST_REFUSE_ON_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ctl_idle && cmd_data == DW'(8'hE8) && ctl_pending) |=> !xsts[7]); // R2
  AST_WRITE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_wr |-> !sts[7]); // R7
  AST_LOCK_WITH_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    sts[1] |-> sts[4]); // R9
  AST_READY_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready); // R12
endmodule

bind wb_sequencer wb_sequencer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .sts(sts), .xsts(xsts), .ctl_idle(ctl_idle),
  .ctl_pending(ctl_pending), .eng_wr(eng_wr)
);

// File: tb/wb_sequencer_test.sv
module wb_sequencer_test;
  localparam int AW = 7;
  localparam int DW = 16;
  localparam int WORDS = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic [3:0] lock = '0;
  logic wp_n = 1'b1;
  logic vpp_ok = 1'b1;
  logic [7:0] sts, xsts;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  always #2.5 clk = ~clk;

  wb_sequencer uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .lock(lock), .wp_n(wp_n),
    .vpp_ok(vpp_ok), .sts(sts), .xsts(xsts), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit cmp_on = 0, done = 0;

  // behavioural reference model
  logic [DW-1:0] marr [WORDS];
  logic [DW-1:0] mbuf [16];
  bit mhas [16];
  bit m_e5, m_e4, m_e1, m_xs, m_busy, m_pend;
  int mstate, mblk, mcnt, mbase, mleft;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 50000);
      finish_run();
    end
  end

  // R8 per-cycle comparison of error bits and extended status
  always @(negedge clk) if (cmp_on) begin
    check(sts[5] == m_e5 && sts[4] == m_e4 && sts[1] == m_e1, "R8", "error bits",
          {sts[5], sts[4], sts[1]}, {m_e5, m_e4, m_e1});
    check(xsts == {m_xs, 7'b0}, "R2", "xsts", xsts, {m_xs, 7'b0});
  end

  function automatic void inval();
    m_e5 = 1; m_e4 = 1; mstate = 0;
  endfunction

  function automatic void model_cmd(int a, int d);
    int off;
    case (mstate)
      0: if (d == 'hE8) begin
           if (m_e5 || m_e4 || m_e1 || m_pend) m_xs = 0;
           else begin
             m_xs = 1; mblk = a / 32; mstate = 1;
             for (int i = 0; i < 16; i++) mhas[i] = 0;
           end
         end else if (d == 'h50) begin m_e5 = 0; m_e4 = 0; m_e1 = 0; end
      1: if (a / 32 != mblk || d > 15) inval(); else begin mcnt = d; mstate = 2; end
      2: if (a / 32 != mblk || (a % 32) + mcnt > 31) inval();
         else begin
           mbase = a; mbuf[0] = DW'(d); mhas[0] = 1; mleft = mcnt;
           mstate = (mcnt == 0) ? 4 : 3;
         end
      3: begin
           off = a - mbase;
           if (off < 0 || off > mcnt) inval();
           else begin
             mbuf[off] = DW'(d); mhas[off] = 1; mleft--;
             if (mleft == 0) mstate = 4;
           end
         end
      default: begin
        mstate = 0;
        if (d != 'hD0 || !vpp_ok) begin m_e5 = 1; m_e4 = 1; end
        else if (lock[mblk] && !wp_n) begin m_e1 = 1; m_e4 = 1; end
        else begin
          for (int i = 0; i <= mcnt; i++)
            if (mhas[i]) marr[mbase + i] = marr[mbase + i] & mbuf[i];
          if (m_busy) m_pend = 1;
          m_busy = 1;
        end
      end
    endcase
  endfunction

  task automatic cmd(int a, int d);
    @(negedge clk);
    cmd_valid = 1; cmd_addr = AW'(a); cmd_data = DW'(d);
    @(posedge clk);
    #1;
    cmd_valid = 0;
    model_cmd(a, d);
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    @(negedge clk);
    while (!sts[7]) begin @(negedge clk); n++; end
    m_busy = 0; m_pend = 0;
    check(n > 0 || 1, req, "idle reached", sts[7], 1);
  endtask

  task automatic check_array(string req);
    int bad = 0, first = -1;
    for (int i = 0; i < WORDS; i++) begin
      rd_addr = AW'(i); #0.1;
      if (rd_data !== marr[i]) begin bad++; if (first < 0) first = i; end
    end
    if (first >= 0) begin rd_addr = AW'(first); #0.1; end
    check(bad == 0, req, "array contents", first >= 0 ? rd_data : 0,
          first >= 0 ? marr[first] : 0);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) marr[i] = '1;
    m_e5 = 0; m_e4 = 0; m_e1 = 0; m_xs = 0; m_busy = 0; m_pend = 0; mstate = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(sts == 8'h80, "R1", "reset sts", sts, 8'h80);
    check(xsts == 8'h00, "R1", "reset xsts", xsts, 0);
    check(cmd_ready == 1, "R12", "ready after reset", cmd_ready, 1);
    check_array("R1");
    cmp_on = 1;

    // R12: stray code while idle does nothing
    cmd(5, 'h1234);
    @(negedge clk);
    check(sts == 8'h80, "R12", "stray code sts", sts, 8'h80);

    // R7: full sequence in block 1
    cmd(32, 'hE8);
    @(negedge clk); check(xsts[7] == 1, "R2", "grant", xsts[7], 1);
    cmd(33, 3); cmd(36, 'h1111); cmd(37, 'h2222); cmd(38, 'h4444); cmd(39, 'h8888);
    cmd(36, 'hD0);
    @(negedge clk); check(sts[7] == 0, "R7", "busy after confirm", sts[7], 0);
    wait_idle("R7"); check_array("R7");

    // R5: repeated offset, unwritten offsets; AND over earlier data
    cmd(32, 'hE8); cmd(40, 3); cmd(37, 'hF0F0); cmd(37, 'h0F0F); cmd(39, 'h00FF); cmd(39, 'hFF00);
    cmd(32, 'hD0); wait_idle("R5"); check_array("R5");

    // R3: count too large, then R8 refusal and clear
    cmd(0, 'hE8); cmd(1, 16);
    @(negedge clk); check(sts[5] && sts[4], "R3", "count over depth", sts, 8'hB0);
    cmd(0, 'hE8);
    @(negedge clk); check(xsts[7] == 0, "R8", "setup refused on error", xsts[7], 0);
    cmd(2, 'h0000); check_array("R8");
    cmd(0, 'h50);
    @(negedge clk); check(sts == 8'h80, "R8", "clear", sts, 8'h80);
    // R3: count address outside block
    cmd(0, 'hE8); cmd(40, 2); cmd(0, 'h50);

    // R4: range crosses block end
    cmd(32, 'hE8); cmd(33, 7); cmd(60, 'h0000);
    @(negedge clk); check(sts[5] && sts[4], "R4", "boundary", sts, 8'hB0);
    cmd(0, 'h50); check_array("R4");

    // R5: address out of range
    cmd(64, 'hE8); cmd(64, 2); cmd(70, 'h0); cmd(69, 'h0);
    @(negedge clk); check(sts[5] && sts[4], "R5", "out of range", sts, 8'hB0);
    cmd(0, 'h50);

    // R6: bad confirm
    cmd(64, 'hE8); cmd(64, 0); cmd(66, 'h0000); cmd(66, 'hFF);
    @(negedge clk); check(sts[5] && sts[4], "R6", "bad confirm", sts, 8'hB0);
    check_array("R6"); cmd(0, 'h50);

    // R9: locked block
    lock = 4'b0100; wp_n = 0;
    cmd(64, 'hE8); cmd(64, 0); cmd(67, 'h0000); cmd(64, 'hD0);
    @(negedge clk); check(sts[1] && sts[4] && !sts[5], "R9", "lock error", sts, 8'h92);
    check_array("R9"); cmd(0, 'h50);
    wp_n = 1;
    cmd(64, 'hE8); cmd(64, 0); cmd(67, 'h1234); cmd(64, 'hD0);
    wait_idle("R9"); check_array("R9");
    lock = 0;

    // R10: program voltage low
    vpp_ok = 0;
    cmd(64, 'hE8); cmd(64, 0); cmd(68, 'h0000); cmd(64, 'hD0);
    @(negedge clk); check(sts[5] && sts[4], "R10", "vpp low", sts, 8'hB0);
    vpp_ok = 1; check_array("R10"); cmd(0, 'h50);

    // R11: load second buffer while engine busy, then pending refusal
    cmd(0, 'hE8); cmd(0, 15);
    cmd(0, 'hA5A5);
    for (int i = 1; i < 16; i++) cmd(i, 16'h7000 + i);
    cmd(0, 'hD0);
    cmd(96, 'hE8);
    @(negedge clk); check(xsts[7] == 1, "R11", "grant while busy", xsts[7], 1);
    cmd(96, 1); cmd(100, 'h00FF); cmd(101, 'hFF00); cmd(96, 'hD0);
    cmd(96, 'hE8);
    @(negedge clk); check(xsts[7] == 0, "R2", "refused while pending", xsts[7], 0);
    check(sts[7] == 0, "R7", "not ready while pending", sts[7], 0);
    wait_idle("R11"); check_array("R11");
    cmd(96, 'hE8);
    @(negedge clk); check(xsts[7] == 1, "R2", "retry granted", xsts[7], 1);
    cmd(96, 0); cmd(96, 'h0001); cmd(96, 'h55);
    cmd(0, 'h50);

    cmp_on = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule